// File: doc/BRIEF.md
# Serial Memory Page-Write Target

This block is the write side of a two-wire (I2C) memory target. It oversamples SCL and SDA on a fast system clock and finds START and STOP conditions. It accepts a transaction only when the first byte carries its 7-bit device address with the write direction. After that it takes a 16-bit word address as two bytes, high byte first, followed by any number of data bytes. The data bytes are staged in a page buffer. A per-byte valid mask records which buffer entries the transaction loaded.

A STOP that follows at least one data byte starts a timed write cycle. During that cycle the staged bytes are copied into an internal byte array, and the `busy` output stays high. For the whole cycle the target ignores the bus: it never pulls SDA low and keeps no part of anything it sees. The array can be read at any time through a combinational side port, which the surrounding checks use.

SDA is open-drain. `sdaOe` high means the target pulls the line low; otherwise the line is released.

Top module: `pageWriteTarget`

## Requirements
- R1: The target acknowledges a first byte only when its upper seven bits equal `1010` followed by the `DEV_SEL` parameter and its lowest bit (direction) is 0. Any other first byte is not acknowledged, the rest of that transaction is ignored and the array is unchanged.
- R2: In an accepted write, the target acknowledges the address-high byte, the address-low byte and every data byte. It acknowledges by holding SDA low while SCL is high during the ninth clock pulse of the byte, and it releases SDA after that pulse.
- R3: Each data byte goes to the current in-page offset, which is the low 5 address bits. The offset then increments and wraps from 31 to 0, while the page bits stay unchanged. For example, 32 bytes written from offset 16 fill offsets 16..31 and then 0..15.
- R4: When more than 32 data bytes are sent, the later bytes overwrite the earlier staged bytes in wrap order. Byte 33 of a transaction that starts at offset 16 lands at offset 16.
- R5: A commit writes only the offsets loaded in that transaction. Every other byte of the page keeps its earlier contents.
- R6: A STOP after at least one data byte raises `busy` for exactly `WRITE_CYCLES` clock cycles. When `busy` falls, the array holds the new bytes.
- R7: A STOP that comes before any data byte does not raise `busy` and leaves the array unchanged.
- R8: While `busy` is high, `sdaOe` stays low and no byte is acknowledged. Bus activity during that time, including activity that continues after `busy` falls without a new START, changes nothing.
- R9: Word-address bits at and above `WORD_BITS` (default 11) are ignored. Address 0xF845 therefore selects byte 0x045.
- R10: After reset, `busy` and `sdaOe` are low.
- R11: A repeated START before any STOP discards the bytes staged so far. A STOP that follows it with no new data bytes starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock as seen on the bus |
| sdaIn | input | 1 | Serial data as seen on the bus |
| sdaOe | output | 1 | High to pull SDA low (acknowledge) |
| busy | output | 1 | High during the internal write cycle |
| rdAddr | input | WORD_BITS | Side read port byte address |
| rdData | output | 8 | Array byte at `rdAddr`, combinational |

## Verification
The hardest case to reach is bus traffic that overlaps the write cycle. The bench starts a second transaction immediately after the STOP that begins a commit. That transaction is longer than the busy window, so its first bytes arrive while the target is deaf. Its remaining bytes arrive after `busy` falls but with no fresh START. The bench then checks three things: no byte was acknowledged, no second write cycle began, and the bytes that transaction aimed at still hold their earlier values. The wrap and overwrite orderings are reached by starting transactions mid-page and sending 32, 33 and 40 bytes.

// File: rtl/pageWritePkg.sv
package pageWritePkg;

  typedef struct packed {
    logic       loadHi;
    logic       loadLo;
    logic       loadData;
    logic       commit;
    logic       discard;
    logic [7:0] rxByte;
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_DATA,
    ST_SKIP
  } busState_t;

  typedef enum logic [1:0] {
    ACK_NONE,
    ACK_WAIT,
    ACK_DRIVE
  } ackPhase_t;

endpackage

// File: rtl/pageWriteCtrl.sv
module pageWriteCtrl
  import pageWritePkg::*;
#(
  parameter logic [2:0] DEV_SEL = 3'b000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclIn,
  input  logic         sdaIn,
  input  logic         busy,
  output logic         sdaOe,
  output ctrlStrobes_t strobes
);

  localparam logic [6:0] DEV_ID = {4'b1010, DEV_SEL};

  logic [1:0] sclPipe, sdaPipe;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS;
  logic       sclRise, sclFall, startCond, stopCond;

  busState_t  state, nextState;
  ackPhase_t  ackPhase;
  logic [2:0] bitCnt;
  logic [7:0] shiftReg, shiftNext;
  logic       gotData;
  logic       receiving, byteDone, byteAck;

  assign sclS      = sclPipe[1];
  assign sdaS      = sdaPipe[1];
  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startCond = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopCond  = sclS & sclPrev & ~sdaPrev & sdaS;

  assign shiftNext = {shiftReg[6:0], sdaS};
  assign receiving = (state != ST_IDLE) && (state != ST_SKIP);
  assign byteDone  = !busy && !startCond && !stopCond && receiving &&
                     (ackPhase == ACK_NONE) && sclRise && (bitCnt == 3'd7);

  always_comb begin
    nextState = state;
    byteAck   = 1'b0;
    unique case (state)
      ST_DEV: begin
        if (shiftNext[7:1] == DEV_ID && !shiftNext[0]) begin
          nextState = ST_ADDR_HI;
          byteAck   = 1'b1;
        end else begin
          nextState = ST_SKIP;
        end
      end
      ST_ADDR_HI: begin nextState = ST_ADDR_LO; byteAck = 1'b1; end
      ST_ADDR_LO: begin nextState = ST_DATA;    byteAck = 1'b1; end
      ST_DATA:    begin nextState = ST_DATA;    byteAck = 1'b1; end
      default:    nextState = state;
    endcase
  end

  always_comb begin
    strobes          = '0;
    strobes.rxByte   = shiftNext;
    strobes.loadHi   = byteDone && (state == ST_ADDR_HI);
    strobes.loadLo   = byteDone && (state == ST_ADDR_LO);
    strobes.loadData = byteDone && (state == ST_DATA);
    strobes.commit   = !busy && stopCond && gotData;
    strobes.discard  = !busy && startCond && gotData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe  <= 2'b11;
      sdaPipe  <= 2'b11;
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
      state    <= ST_IDLE;
      ackPhase <= ACK_NONE;
      bitCnt   <= '0;
      shiftReg <= '0;
      gotData  <= 1'b0;
    end else begin
      sclPipe <= {sclPipe[0], sclIn};
      sdaPipe <= {sdaPipe[0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
      if (busy) begin
        state    <= ST_IDLE;
        ackPhase <= ACK_NONE;
        bitCnt   <= '0;
        gotData  <= 1'b0;
      end else if (startCond) begin
        state    <= ST_DEV;
        ackPhase <= ACK_NONE;
        bitCnt   <= '0;
        gotData  <= 1'b0;
      end else if (stopCond) begin
        state    <= ST_IDLE;
        ackPhase <= ACK_NONE;
        bitCnt   <= '0;
        gotData  <= 1'b0;
      end else if (ackPhase == ACK_WAIT && sclFall) begin
        ackPhase <= ACK_DRIVE;
      end else if (ackPhase == ACK_DRIVE && sclFall) begin
        ackPhase <= ACK_NONE;
      end else if (ackPhase == ACK_NONE && sclRise && receiving) begin
        shiftReg <= shiftNext;
        bitCnt   <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          state <= nextState;
          if (byteAck) ackPhase <= ACK_WAIT;
          if (state == ST_DATA) gotData <= 1'b1;
        end
      end
    end
  end

  assign sdaOe = (ackPhase == ACK_DRIVE);

  // R8: never pull the line while the write cycle runs
  p_quiet_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe);

  // R2: acknowledge begins only while SCL is low
  p_ack_scl_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclS);

  // R2: acknowledge is not dropped while SCL is high
  p_ack_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe && sclS && !busy) |=> sdaOe || !sclS);

endmodule

// File: rtl/pageWriteData.sv
module pageWriteData
  import pageWritePkg::*;
#(
  parameter int WORD_BITS    = 11,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 400
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [WORD_BITS-1:0] rdAddr,
  output logic [7:0]           rdData,
  output logic                 busy
);

  localparam int OFF_BITS = $clog2(PAGE_BYTES);
  localparam int DEPTH    = 1 << WORD_BITS;
  localparam int CNT_BITS = $clog2(WRITE_CYCLES + 1);

  logic [7:0]            mem [DEPTH];
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validMask;
  logic [7:0]            addrHiReg;
  logic [15:0]           fullAddr;
  logic [WORD_BITS-1:0]  wordAddr;
  logic [OFF_BITS-1:0]   offset;
  logic [OFF_BITS:0]     copyIdx;
  logic [CNT_BITS-1:0]   busyCnt;
  logic                  busyActive;
  logic                  memWe;
  logic [WORD_BITS-1:0]  memAddr;

  assign fullAddr = {addrHiReg, strobes.rxByte};
  assign offset   = wordAddr[OFF_BITS-1:0];
  assign memWe    = busyActive && !copyIdx[OFF_BITS] &&
                    validMask[copyIdx[OFF_BITS-1:0]];
  assign memAddr  = {wordAddr[WORD_BITS-1:OFF_BITS], copyIdx[OFF_BITS-1:0]};
  assign busy     = busyActive;
  assign rdData   = mem[rdAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHiReg  <= '0;
      wordAddr   <= '0;
      validMask  <= '0;
      copyIdx    <= '0;
      busyCnt    <= '0;
      busyActive <= 1'b0;
    end else begin
      if (strobes.loadHi) addrHiReg <= strobes.rxByte;
      if (strobes.loadLo) wordAddr  <= fullAddr[WORD_BITS-1:0];
      if (strobes.loadData) begin
        validMask[offset]          <= 1'b1;
        wordAddr[OFF_BITS-1:0]     <= offset + OFF_BITS'(1);
      end
      if (strobes.discard) validMask <= '0;
      if (strobes.commit) begin
        busyActive <= 1'b1;
        busyCnt    <= '0;
        copyIdx    <= '0;
      end else if (busyActive) begin
        if (!copyIdx[OFF_BITS]) copyIdx <= copyIdx + 1'b1;
        if (busyCnt == CNT_BITS'(WRITE_CYCLES - 1)) begin
          busyActive <= 1'b0;
          validMask  <= '0;
        end else begin
          busyCnt <= busyCnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.loadData) pageBuf[offset] <= strobes.rxByte;
    if (memWe) mem[memAddr] <= pageBuf[copyIdx[OFF_BITS-1:0]];
  end

  // Independent run counter for the busy window length
  int busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= 0;
  end

  // R6: busy spans exactly the configured number of cycles
  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyRun == WRITE_CYCLES);

  // R5: nothing staged survives a finished commit
  p_mask_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> validMask == '0);

  // R3: a data byte never moves the page bits
  p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadData |=> wordAddr[WORD_BITS-1:OFF_BITS] ==
                         $past(wordAddr[WORD_BITS-1:OFF_BITS]));

  // R8: control issues no strobe during the write cycle
  p_no_strobe_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strobes.loadHi || strobes.loadLo || strobes.loadData ||
               strobes.commit));

endmodule

// File: rtl/pageWriteTarget.sv
module pageWriteTarget
  import pageWritePkg::*;
#(
  parameter logic [2:0] DEV_SEL      = 3'b000,
  parameter int         WORD_BITS    = 11,
  parameter int         PAGE_BYTES   = 32,
  parameter int         WRITE_CYCLES = 400
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  output logic                 sdaOe,
  output logic                 busy,
  input  logic [WORD_BITS-1:0] rdAddr,
  output logic [7:0]           rdData
);

  ctrlStrobes_t strobes;

  pageWriteCtrl #(
    .DEV_SEL(DEV_SEL)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .busy    (busy),
    .sdaOe   (sdaOe),
    .strobes (strobes)
  );

  pageWriteData #(
    .WORD_BITS    (WORD_BITS),
    .PAGE_BYTES   (PAGE_BYTES),
    .WRITE_CYCLES (WRITE_CYCLES)
  ) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .busy    (busy)
  );

endmodule

// File: tb/pageWriteTarget_bench.sv
module pageWriteTarget_bench;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int WB         = 11;
  localparam int WCYC       = 400;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaLine;
  logic sdaOe, busy;
  logic [WB-1:0] rdAddr = '0;
  logic [7:0] rdData;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  pageWriteTarget #(.WORD_BITS(WB), .WRITE_CYCLES(WCYC)) u_pageWriteTarget (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .busy(busy), .rdAddr(rdAddr), .rdData(rdData)
  );

  typedef struct {
    int         addr;
    logic [7:0] val;
    string      req;
  } expItem_t;

  expItem_t   expQ[$];
  logic [7:0] model [int];
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int busyLen = 0, lastLen = 0, busyRises = 0, overlapBad = 0;
  logic prevBusy = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (busy && sdaOe) overlapBad++;
    if (busy && !prevBusy) busyRises++;
    if (busy) busyLen++;
    else if (busyLen != 0) begin lastLen = busyLen; busyLen = 0; end
    prevBusy = busy;
  end

  // Monitor: pop expected bytes once the write cycle has finished
  initial begin
    forever begin
      @(negedge clk);
      if (!busy && expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        rdAddr = it.addr[WB-1:0];
        #1;
        check(rdData === it.val, it.req, "array byte", rdData, it.val);
      end
    end
  end

  task automatic quarter(); repeat (Q) @(negedge clk); endtask

  task automatic startBit();
    sdaM = 1; quarter(); sclM = 1; quarter(); sdaM = 0; quarter(); sclM = 0; quarter();
  endtask

  task automatic stopBit();
    sdaM = 0; quarter(); sclM = 1; quarter(); sdaM = 1; quarter();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; quarter(); sclM = 1; quarter(); quarter(); sclM = 0; quarter();
    end
    sdaM = 1; quarter(); sclM = 1; quarter();
    acked = (sdaLine == 1'b0);
    quarter(); sclM = 0; quarter();
  endtask

  // Driver: run one write and push the expected page contents
  task automatic doWrite(input logic [6:0] dev, input logic rw,
                         input logic [15:0] waddr, input int n,
                         input logic [7:0] seed, input bit doStop,
                         input bit pushExp, input int expAcks,
                         input string req);
    int acks = 0;
    bit a;
    logic [7:0] stage [32];
    bit valid [32];
    int base, off;
    startBit();
    sendByte({dev, rw}, a); acks += int'(a);
    sendByte(waddr[15:8], a); acks += int'(a);
    sendByte(waddr[7:0], a); acks += int'(a);
    for (int i = 0; i < n; i++) begin
      sendByte(seed + 8'(i * 3), a); acks += int'(a);
    end
    if (doStop) stopBit();
    check(acks == expAcks, req, "ack count", acks, expAcks);
    if (pushExp) begin
      base = int'(waddr) & ((1 << WB) - 1) & ~31;
      off  = int'(waddr[4:0]);
      for (int j = 0; j < 32; j++) valid[j] = 0;
      for (int i = 0; i < n; i++) begin
        stage[off] = seed + 8'(i * 3);
        valid[off] = 1;
        off = (off + 1) % 32;
      end
      for (int j = 0; j < 32; j++) begin
        if (valid[j]) model[base + j] = stage[j];
        if (model.exists(base + j))
          expQ.push_back('{base + j, model[base + j], req});
      end
    end
  endtask

  task automatic awaitDone();
    repeat (4) @(negedge clk);
    wait (!busy);
    wait (expQ.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic readCheck(input int addr, input string req);
    rdAddr = addr[WB-1:0];
    #1;
    check(rdData === model[addr], req, "unchanged byte", rdData, model[addr]);
  endtask

  task automatic noCommit(input int risesBefore, input string req);
    repeat (20) @(negedge clk);
    check(busyRises == risesBefore && !busy, req, "write cycle started",
          busyRises - risesBefore, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish();
  end

  initial begin
    int rises;
    repeat (3) @(negedge clk);
    check(busy == 0, "R10", "busy after reset", busy, 0);
    check(sdaOe == 0, "R10", "sdaOe after reset", sdaOe, 0);
    rstN = 1;
    repeat (5) @(negedge clk);

    // R1 R2 R6: full page from offset 0
    doWrite(DEV, 0, 16'h0040, 32, 8'h10, 1, 1, 35, "R2");
    awaitDone();
    check(lastLen == WCYC, "R6", "busy length", lastLen, WCYC);

    // R5: three bytes into a filled page
    doWrite(DEV, 0, 16'h0045, 3, 8'hA0, 1, 1, 6, "R5");
    awaitDone();

    // R3: wrap from offset 16
    doWrite(DEV, 0, 16'h0090, 32, 8'h21, 1, 1, 35, "R3");
    awaitDone();

    // R4: 33 and 40 bytes overwrite in wrap order
    doWrite(DEV, 0, 16'h00D0, 33, 8'h05, 1, 1, 36, "R4");
    awaitDone();
    doWrite(DEV, 0, 16'h0103, 40, 8'h77, 1, 1, 43, "R4");
    awaitDone();

    // R1: wrong device address and read direction
    rises = busyRises;
    doWrite(7'h51, 0, 16'h0041, 2, 8'hEE, 1, 0, 0, "R1");
    noCommit(rises, "R1");
    readCheck(16'h0041, "R1");
    doWrite(DEV, 1, 16'h0041, 2, 8'hEE, 1, 0, 0, "R1");
    noCommit(rises, "R1");
    readCheck(16'h0041, "R1");

    // R7: stop right after the address
    rises = busyRises;
    doWrite(DEV, 0, 16'h0043, 0, 8'h00, 1, 0, 3, "R7");
    noCommit(rises, "R7");

    // R11: repeated start discards staged bytes
    rises = busyRises;
    doWrite(DEV, 0, 16'h0048, 4, 8'h99, 0, 0, 7, "R11");
    startBit();
    stopBit();
    noCommit(rises, "R11");
    readCheck(16'h0048, "R11");
    readCheck(16'h0049, "R11");

    // R9: high address bits are dropped
    doWrite(DEV, 0, 16'hF845, 2, 8'h3C, 1, 1, 5, "R9");
    awaitDone();

    // R8: traffic that overlaps the write cycle
    doWrite(DEV, 0, 16'h0060, 2, 8'h55, 1, 1, 5, "R6");
    rises = busyRises;
    doWrite(DEV, 0, 16'h0042, 4, 8'hC3, 1, 0, 0, "R8");
    awaitDone();
    noCommit(rises, "R8");
    readCheck(16'h0042, "R8");
    readCheck(16'h0044, "R8");
    check(overlapBad == 0, "R8", "sdaOe while busy", overlapBad, 0);

    finish();
  end

endmodule